// File: doc/BRIEF.md
# Warp Lane Divergence Mask Controller

This block holds the active lane mask of a single warp in a lockstep machine. The lanes run one shared instruction stream. A conditional branch can split the lanes into two groups. When that happens, the block runs the two sides in turn. First the lanes that chose the branch run while the others sit idle. Then the other lanes run while the first group waits. At the merge point the mask the warp had before the branch comes back. If every live lane picks the same way, nothing splits and the warp keeps going under its current mask.

An external sequencer supplies the events. A branch event carries a per-lane direction vector. An end-of-path strobe marks the end of the first side and, on its second use, the merge point. Split branches nest on a small save stack. Lanes outside the mask still execute, but the block clears their bits in the writeback enable. Because the sides run back to back, a split branch costs the cycles of both sides added together.

Top module: `dmc_divergence_ctrl`

## Requirements
- R1: After reset the active mask is all ones, the path indicator is 00 (converged), the nesting depth is 0 and the overflow flag is 0.
- R2: A branch event that splits the live lanes loads the mask with (mask AND taken vector) on the next clock, sets the path indicator to 01 (first side) and adds one to the depth.
- R3: An end-of-path strobe while the innermost split is on its first side loads the mask with (pre-branch mask AND NOT taken vector) and sets the path indicator to 10 (second side). The depth does not change.
- R4: An end-of-path strobe while the innermost split is on its second side brings back the pre-branch mask and path indicator, and removes one from the depth.
- R5: A branch event whose live lanes all agree, meaning (mask AND taken) is zero or (mask AND NOT taken) is zero, leaves the mask, path and depth unchanged.
- R6: Splits nest up to 4 deep. Each level unwinds in reverse order to the mask it saved.
- R7: Any branch event that arrives while the depth is 4 sets the overflow flag, which then stays set until reset. Mask, path and depth do not change.
- R8: An end-of-path strobe at depth 0 is ignored.
- R9: When a branch event and an end-of-path strobe arrive in the same cycle, only the branch event is acted on.
- R10: The writeback enable equals the requested writeback lanes AND the current active mask, in the same cycle.
- R11: The active mask is never zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Branch event strobe |
| br_taken_i | input | 32 | Per-lane branch direction, 1 = chose the branch |
| path_end_i | input | 1 | End of the current side / merge point |
| wb_req_i | input | 32 | Lanes requesting register writeback |
| active_mask_o | output | 32 | Current active lane mask |
| path_o | output | 2 | 00 converged, 01 first side, 10 second side |
| depth_o | output | 3 | Number of open split levels |
| overflow_o | output | 1 | Sticky flag for a branch event at full depth |
| wb_commit_o | output | 32 | Gated writeback enable |

## Verification
A wrong saved entry does not show up when it is written. It appears only when the strobe that reads it arrives: the second-side mask shows it one clock after the first strobe, and the restored mask shows it one clock after the second. The bench therefore unwinds every nested level fully and compares the mask and path after each strobe. A depth count that is off by one shows two ways. The overflow flag rises at the wrong nesting level, or a level fails to restore, and either one is visible within a clock of the event that triggers it. Writeback gating is checked in the same cycle under each mask the block reaches.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    PATH_CONV  = 2'b00,
    PATH_TAKEN = 2'b01,
    PATH_ELSE  = 2'b10
  } path_e;
endpackage

// File: rtl/dmc_split.sv
module dmc_split #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] cur_mask_i,
  input  logic [LANES-1:0] taken_i,
  output logic [LANES-1:0] t_mask_o,
  output logic [LANES-1:0] e_mask_o,
  output logic             uniform_o
);
  // per-lane split of the live lanes into the two sides
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign t_mask_o[l] = cur_mask_i[l] & taken_i[l];
    assign e_mask_o[l] = cur_mask_i[l] & ~taken_i[l];
  end
  assign uniform_o = ~(|t_mask_o) | ~(|e_mask_o);
endmodule

// File: rtl/dmc_stack.sv
module dmc_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             flip_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] push_saved_i,
  input  logic [LANES-1:0] push_else_i,
  input  logic [1:0]       push_path_i,
  output logic [LANES-1:0] top_saved_o,
  output logic [LANES-1:0] top_else_o,
  output logic [1:0]       top_path_o,
  output logic             top_in_else_o,
  output logic [PW-1:0]    depth_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [LANES-1:0] saved_q [DEPTH];
  logic [LANES-1:0] else_q  [DEPTH];
  logic [1:0]       path_q  [DEPTH];
  logic             phase_q [DEPTH];
  logic [PW-1:0]    cnt_q, cnt_d;
  logic [PW-1:0]    cnt_m1;
  logic [IW-1:0]    top_idx;

  assign cnt_m1  = cnt_q - PW'(1);
  assign top_idx = cnt_m1[IW-1:0];
  assign full_o  = (cnt_q == PW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign depth_o = cnt_q;

  // one register set per level, each with its own write and flip enables
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wr_en, flip_en;
    assign wr_en   = push_i && (cnt_q == PW'(g));
    assign flip_en = flip_i && (cnt_q == PW'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        saved_q[g] <= '0;
        else_q[g]  <= '0;
        path_q[g]  <= '0;
        phase_q[g] <= 1'b0;
      end else if (wr_en) begin
        saved_q[g] <= push_saved_i;
        else_q[g]  <= push_else_i;
        path_q[g]  <= push_path_i;
        phase_q[g] <= 1'b0;
      end else if (flip_en) begin
        phase_q[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (empty_o) begin
      top_saved_o   = '0;
      top_else_o    = '0;
      top_path_o    = '0;
      top_in_else_o = 1'b0;
    end else begin
      top_saved_o   = saved_q[top_idx];
      top_else_o    = else_q[top_idx];
      top_path_o    = path_q[top_idx];
      top_in_else_o = phase_q[top_idx];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !full_o)      cnt_d = cnt_q + PW'(1);
    else if (pop_i && !empty_o) cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PW'(DEPTH));
  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && full_o));
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((pop_i || flip_i) && empty_o));
endmodule

// File: rtl/dmc_wb_gate.sv
module dmc_wb_gate #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] req_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] commit_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_gate
    assign commit_o[l] = req_i[l] & mask_i[l];
  end
endmodule

// File: rtl/dmc_divergence_ctrl.sv
module dmc_divergence_ctrl
  import dmc_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid_i,
  input  logic [LANES-1:0] br_taken_i,
  input  logic             path_end_i,
  input  logic [LANES-1:0] wb_req_i,
  output logic [LANES-1:0] active_mask_o,
  output logic [1:0]       path_o,
  output logic [PW-1:0]    depth_o,
  output logic             overflow_o,
  output logic [LANES-1:0] wb_commit_o
);
  logic [LANES-1:0] mask_q, mask_d;
  path_e            path_q, path_d;
  logic             ovf_q, ovf_d;

  logic [LANES-1:0] t_mask, e_mask;
  logic             uniform;
  logic             push, flip, pop;
  logic [LANES-1:0] top_saved, top_else;
  logic [1:0]       top_path;
  logic             top_in_else, full, empty;
  logic [PW-1:0]    depth;

  dmc_split #(.LANES(LANES)) u_split (
    .cur_mask_i(mask_q), .taken_i(br_taken_i),
    .t_mask_o(t_mask), .e_mask_o(e_mask), .uniform_o(uniform)
  );

  dmc_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .flip_i(flip), .pop_i(pop),
    .push_saved_i(mask_q), .push_else_i(e_mask), .push_path_i(path_q),
    .top_saved_o(top_saved), .top_else_o(top_else), .top_path_o(top_path),
    .top_in_else_o(top_in_else), .depth_o(depth), .full_o(full), .empty_o(empty)
  );

  dmc_wb_gate #(.LANES(LANES)) u_gate (
    .req_i(wb_req_i), .mask_i(mask_q), .commit_o(wb_commit_o)
  );

  // next state: branch events win over end-of-path strobes
  always_comb begin
    mask_d = mask_q;
    path_d = path_q;
    ovf_d  = ovf_q;
    push   = 1'b0;
    flip   = 1'b0;
    pop    = 1'b0;
    if (br_valid_i) begin
      if (full) begin
        ovf_d = 1'b1;
      end else if (!uniform) begin
        push   = 1'b1;
        mask_d = t_mask;
        path_d = PATH_TAKEN;
      end
    end else if (path_end_i && !empty) begin
      if (!top_in_else) begin
        flip   = 1'b1;
        mask_d = top_else;
        path_d = PATH_ELSE;
      end else begin
        pop    = 1'b1;
        mask_d = top_saved;
        path_d = path_e'(top_path);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      path_q <= PATH_CONV;
      ovf_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      path_q <= path_d;
      ovf_q  <= ovf_d;
    end
  end

  assign active_mask_o = mask_q;
  assign path_o        = path_q;
  assign depth_o       = depth;
  assign overflow_o    = ovf_q;

  p_mask_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != '0);
  p_push_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_i && !full && !uniform) |=> (depth == $past(depth) + PW'(1)));
  p_uniform_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_i && !full && uniform) |=> ($stable(mask_q) && $stable(depth)));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_i && full) |=> (ovf_q && $stable(mask_q) && $stable(depth)));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  p_idle_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (path_end_i && !br_valid_i && empty) |=> $stable(mask_q));
  p_conv_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (path_q == PATH_CONV));
  p_commit_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_commit_o & ~mask_q) == '0);
endmodule

// File: tb/dmc_divergence_ctrl_bench.sv
module dmc_divergence_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid;
  logic [31:0] br_taken;
  logic        path_end;
  logic [31:0] wb_req;
  logic [31:0] active_mask;
  logic [1:0]  path;
  logic [2:0]  depth;
  logic        overflow;
  logic [31:0] wb_commit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] m_mask;
  int          m_path;
  bit          m_ovf;
  logic [31:0] q_saved[$];
  logic [31:0] q_else[$];
  int          q_path[$];
  bit          q_phase[$];
  string       last_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmc_divergence_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_dmc_divergence_ctrl (
    .clk(clk), .rst_n(rst_n),
    .br_valid_i(br_valid), .br_taken_i(br_taken),
    .path_end_i(path_end), .wb_req_i(wb_req),
    .active_mask_o(active_mask), .path_o(path), .depth_o(depth),
    .overflow_o(overflow), .wb_commit_o(wb_commit)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_state(input string req);
    chk(req, "mask", active_mask, m_mask);
    chk(req, "path", {30'd0, path}, m_path);
    chk(req, "depth", {29'd0, depth}, q_saved.size());
    chk(req, "overflow", {31'd0, overflow}, {31'd0, m_ovf});
  endtask

  function automatic void model_clock(input bit br, input logic [31:0] tk, input bit pe);
    logic [31:0] t, e;
    int idx;
    if (br) begin
      if (q_saved.size() == DEPTH) m_ovf = 1;
      else begin
        t = m_mask & tk;
        e = m_mask & ~tk;
        if (t != 0 && e != 0) begin
          q_saved.push_back(m_mask); q_else.push_back(e);
          q_path.push_back(m_path);  q_phase.push_back(0);
          m_mask = t; m_path = 1;
        end
      end
    end else if (pe && q_saved.size() > 0) begin
      idx = q_saved.size() - 1;
      if (!q_phase[idx]) begin
        q_phase[idx] = 1; m_mask = q_else[idx]; m_path = 2;
      end else begin
        m_mask = q_saved[idx]; m_path = q_path[idx];
        void'(q_saved.pop_back()); void'(q_else.pop_back());
        void'(q_path.pop_back());  void'(q_phase.pop_back());
      end
    end
  endfunction

  task automatic step(input bit br, input logic [31:0] tk, input bit pe,
                      input logic [31:0] wr, input string req);
    @(negedge clk);
    compare_state(last_req);
    br_valid = br; br_taken = tk; path_end = pe; wb_req = wr;
    #1;
    chk("R10", "wb_commit", wb_commit, wr & m_mask);
    @(posedge clk);
    model_clock(br, tk, pe);
    last_req = req;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; br_valid = 0; br_taken = '0; path_end = 0; wb_req = '0;
    m_mask = '1; m_path = 0; m_ovf = 0; last_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state and R10 under the full mask
    step(0, '0, 0, 32'hA5A5_0F0F, "R1");
    // R5 uniform branches: all choose, none choose
    step(1, 32'hFFFF_FFFF, 0, 32'h1234_5678, "R5");
    step(1, 32'h0000_0000, 0, 32'h0, "R5");
    // R8 end strobe with nothing open
    step(0, '0, 1, 32'hFFFF_FFFF, "R8");
    // R2 split, R3 second side, R4 merge
    step(1, 32'h0000_FFFF, 0, 32'hFFFF_FFFF, "R2");
    step(0, '0, 0, 32'hFFFF_FFFF, "R2");
    step(0, '0, 1, 32'hFFFF_FFFF, "R3");
    step(0, '0, 0, 32'hF0F0_F0F0, "R3");
    step(0, '0, 1, 32'hFFFF_FFFF, "R4");
    // R6 nest four deep with distinct patterns
    step(1, 32'h00FF_00FF, 0, 32'hFFFF_FFFF, "R6");
    step(1, 32'h0F0F_0F0F, 0, 32'hFFFF_FFFF, "R6");
    // R5 inner uniform: direction only differs in lanes already off
    step(1, 32'hF0F0_F0F0, 0, 32'hFFFF_FFFF, "R5");
    step(1, 32'h3333_3333, 0, 32'hFFFF_FFFF, "R6");
    step(1, 32'h5555_5555, 0, 32'hFFFF_FFFF, "R6");
    // R7 overflow at full depth, then stays set
    step(1, 32'h0000_0001, 0, 32'hFFFF_FFFF, "R7");
    step(1, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, "R7");
    // R9 branch wins over end strobe (at full depth: only overflow)
    step(1, 32'h1111_1111, 1, 32'hFFFF_FFFF, "R9");
    // R6 unwind all levels
    for (int i = 0; i < 2 * DEPTH; i++) begin
      step(0, '0, 1, 32'hFFFF_FFFF, "R6");
    end
    step(0, '0, 1, 32'hFFFF_FFFF, "R8");
    // R9 again at depth 0 with a split: end strobe must not act
    step(1, 32'h8000_0000, 1, 32'hFFFF_FFFF, "R9");
    step(0, '0, 1, 32'hFFFF_FFFF, "R9");
    step(0, '0, 1, 32'h7FFF_FFFF, "R4");
    step(0, '0, 0, 32'hFFFF_FFFF, "R11");
    @(negedge clk);
    compare_state(last_req);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule